// File: doc/BRIEF.md
# Memory-Mapped Serial Port with FIFO Status

This block is a byte-wide serial port that a processor reaches over a simple single-cycle 32-bit register bus. It has four word registers: a receive data register, a transmit data register, a control register and a status register. Bytes written to the transmit register wait in a transmit FIFO. From there a serializer sends them as 8N1 frames at a fixed number of clocks per bit. A deserializer watches the receive line, checks each frame and queues the good bytes in a receive FIFO. Software pops them by reading the receive register.

The transmit FIFO reports only a coarse fill level: empty, at least half full, and full. Line faults are latched in sticky status bits, and software clears each one by writing 1 to it. Every status condition has its own enable bit in the control register, and a single level interrupt is the OR of the enabled conditions. Two control bits flush the FIFOs and clear themselves afterwards. The bus is combinational on reads: `bus_rdata` reflects `bus_addr` in the same cycle, and a read of the receive register pops the FIFO at the closing clock edge.

Top module: `serial_port_mm`

## Requirements
- R1: After reset the control register reads 0, no interrupt is raised, and the status register reads 0x0000_2020 (transmit FIFO empty and transmit ready). Register word offsets: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C status.
- R2: Bytes written to offset 0x04 leave on `txd` in write order. Each frame has one low start bit, eight data bits LSB first and one high stop bit, and each bit lasts CLKS_PER_BIT clocks. The line idles high.
- R3: Status bit 13 is set when the transmit FIFO holds nothing, bit 11 when it holds TX_DEPTH entries, and bit 10 when it holds TX_DEPTH/2 or more. Bit 5 (transmit ready) is set whenever the FIFO is not full.
- R4: A write to offset 0x04 while the transmit FIFO is full is dropped, and the stored bytes are not disturbed.
- R5: Good received bytes are read from offset 0x00 in arrival order, in bits 7..0 with bits 31..8 zero. Each read pops one entry. Status bit 4 stays set while the receive FIFO is not empty.
- R6: A good frame that completes while the receive FIFO is full is discarded and sets sticky status bit 0 (overrun). The bytes already queued are unchanged.
- R7: A frame whose stop bit samples low sets sticky bit 3 (break) if all its data bits were 0, and otherwise sets sticky bit 2 (framing error). Either way the byte is not queued.
- R8: Writing status bits 3..0 with 1 clears the matching sticky flag, and writing 0 leaves it unchanged. Bit 1 (parity) always reads 0, because no parity is carried.
- R9: Writing control bit 15 flushes the transmit FIFO, and bit 14 flushes the receive FIFO. Both bits read back 0 from the second cycle after the write. A frame already being sent completes.
- R10: `irq` is the OR of each status condition ANDed with its enable bit. Control bits 5, 4, 3, 2, 1 and 0 enable transmit ready, receive ready, break, framing, parity and overrun, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect at the clock edge that closes the access, so status is read back on the next bus cycle. The FIFO flush bits take one extra cycle, and the bench reads them several cycles later. A transmitted start bit appears on `txd` one clock after the serializer pops the FIFO. The bench decodes each frame by sampling every bit CLKS_PER_BIT clocks apart, starting half a bit after the falling edge. On the receive side, a byte or error flag becomes visible half a bit into the stop bit, plus the synchronizer stages. The bench therefore completes the whole stop bit and waits a further bit time before it reads status or data. `irq` is combinational from the state, so it is checked on the same half-cycle sample as the register it follows.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int BYTE_W = 8;
   // word index of each register (bus_addr[3:2])
   localparam logic [1:0] IDX_RXD  = 2'd0;
   localparam logic [1:0] IDX_TXD  = 2'd1;
   localparam logic [1:0] IDX_CTRL = 2'd2;
   localparam logic [1:0] IDX_STS  = 2'd3;
   // control bits
   localparam int C_TXFLUSH = 15;
   localparam int C_RXFLUSH = 14;
   // status bits (enable bits 5..0 mirror status bits 5..0)
   localparam int S_TXEMPTY = 13;
   localparam int S_TXFULL  = 11;
   localparam int S_TXHALF  = 10;
   localparam int S_TXRDY   = 5;
   localparam int S_RXRDY   = 4;
   localparam int S_BRK     = 3;
   localparam int S_FRM     = 2;
   localparam int S_PAR     = 1;
   localparam int S_OVR     = 0;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
   } rx_state_t;
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 rdata,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sp_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign count   = cnt;
   assign rdata   = mem[rp];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);
   a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !clr) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
   parameter int CLKS_PER_BIT = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    have_data,
   input  logic [sp_pkg::BYTE_W-1:0] data,
   output logic                    pop,
   output logic                    txd
);
   import sp_pkg::*;
   localparam int DW = $clog2(CLKS_PER_BIT);
   localparam int BW = $clog2(BYTE_W + 2);

   logic            busy;
   logic [BYTE_W:0] sh;
   logic [DW-1:0]   div;
   logic [BW-1:0]   left;

   assign pop = !busy && have_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; sh <= '1; div <= '0; left <= '0; txd <= 1'b1;
      end else if (pop) begin
         busy <= 1'b1;
         txd  <= 1'b0;
         sh   <= {1'b1, data};
         left <= BW'(BYTE_W + 1);
         div  <= DW'(CLKS_PER_BIT - 1);
      end else if (busy) begin
         if (div != '0) begin
            div <= div - 1'b1;
         end else if (left == '0) begin
            busy <= 1'b0;
         end else begin
            txd  <= sh[0];
            sh   <= {1'b1, sh[BYTE_W:1]};
            left <= left - 1'b1;
            div  <= DW'(CLKS_PER_BIT - 1);
         end
      end
   end

   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !txd);
   a_r2_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && !$past(pop)) |-> txd);
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
   parameter int CLKS_PER_BIT = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rxd,
   output logic                      got_byte,
   output logic [sp_pkg::BYTE_W-1:0] byte_out,
   output logic                      frm_evt,
   output logic                      brk_evt
);
   import sp_pkg::*;
   localparam int DW = $clog2(CLKS_PER_BIT);
   localparam int BW = $clog2(BYTE_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sp_rx: SYNC_STAGES must be >= 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sy;
   logic                   rxs;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC_STAGES-2:0], rxd};
   end
   assign rxs = sy[SYNC_STAGES-1];

   rx_state_t         st;
   logic [DW-1:0]     div;
   logic [BW-1:0]     nbit;
   logic [BYTE_W-1:0] sh;

   assign byte_out = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; div <= '0; nbit <= '0; sh <= '0;
         got_byte <= 1'b0; frm_evt <= 1'b0; brk_evt <= 1'b0;
      end else begin
         got_byte <= 1'b0; frm_evt <= 1'b0; brk_evt <= 1'b0;
         case (st)
            RX_IDLE: if (!rxs) begin
               st  <= RX_START;
               div <= DW'(CLKS_PER_BIT/2 - 1);
            end
            RX_START: if (div != '0) div <= div - 1'b1;
               else if (!rxs) begin
                  st <= RX_DATA; nbit <= '0; div <= DW'(CLKS_PER_BIT - 1);
               end else st <= RX_IDLE;
            RX_DATA: if (div != '0) div <= div - 1'b1;
               else begin
                  sh   <= {rxs, sh[BYTE_W-1:1]};
                  div  <= DW'(CLKS_PER_BIT - 1);
                  nbit <= nbit + 1'b1;
                  if (nbit == BW'(BYTE_W - 1)) st <= RX_STOP;
               end
            RX_STOP: if (div != '0) div <= div - 1'b1;
               else if (rxs) begin
                  got_byte <= 1'b1; st <= RX_IDLE;
               end else begin
                  brk_evt <= (sh == '0);
                  frm_evt <= (sh != '0);
                  st      <= RX_WAITHI;
               end
            RX_WAITHI: if (rxs) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end

   a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({got_byte, frm_evt, brk_evt}) <= 1);
endmodule

// File: rtl/serial_port_mm.sv
module serial_port_mm #(
   parameter int CLKS_PER_BIT = 16,
   parameter int TX_DEPTH     = 32,
   parameter int RX_DEPTH     = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        txd,
   input  logic        rxd,
   output logic        irq
);
   import sp_pkg::*;
   localparam int TCW = $clog2(TX_DEPTH+1);
   localparam int RCW = $clog2(RX_DEPTH+1);
   localparam int HALF = TX_DEPTH / 2;

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_div
         $error("serial_port_mm: CLKS_PER_BIT must be >= 4");
      end
   endgenerate

   // bus decode
   logic [1:0] idx;
   logic wr_tx, wr_ctrl, wr_sts, rd_rx;
   assign idx     = bus_addr[3:2];
   assign wr_tx   = bus_sel &&  bus_we && idx == IDX_TXD;
   assign wr_ctrl = bus_sel &&  bus_we && idx == IDX_CTRL;
   assign wr_sts  = bus_sel &&  bus_we && idx == IDX_STS;
   assign rd_rx   = bus_sel && !bus_we && idx == IDX_RXD;

   // control register
   logic [5:0] en;
   logic       fl_tx, fl_rx;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= '0; fl_tx <= 1'b0; fl_rx <= 1'b0;
      end else if (wr_ctrl) begin
         en    <= bus_wdata[5:0];
         fl_tx <= bus_wdata[C_TXFLUSH];
         fl_rx <= bus_wdata[C_RXFLUSH];
      end else begin
         fl_tx <= 1'b0; fl_rx <= 1'b0;
      end
   end

   // transmit path
   logic [BYTE_W-1:0] tx_head;
   logic              tx_empty, tx_full, tx_pop;
   logic [TCW-1:0]    tx_cnt;
   sp_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .clr(fl_tx), .push(wr_tx),
      .wdata(bus_wdata[BYTE_W-1:0]), .pop(tx_pop), .rdata(tx_head),
      .empty(tx_empty), .full(tx_full), .count(tx_cnt));
   sp_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_ser (
      .clk(clk), .rst_n(rst_n), .have_data(!tx_empty && !fl_tx),
      .data(tx_head), .pop(tx_pop), .txd(txd));

   // receive path
   logic [BYTE_W-1:0] rx_byte, rx_head;
   logic              rx_got, frm_evt, brk_evt, rx_empty, rx_full;
   logic [RCW-1:0]    rx_cnt;
   sp_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) i_des (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .got_byte(rx_got),
      .byte_out(rx_byte), .frm_evt(frm_evt), .brk_evt(brk_evt));
   sp_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .clr(fl_rx), .push(rx_got),
      .wdata(rx_byte), .pop(rd_rx), .rdata(rx_head),
      .empty(rx_empty), .full(rx_full), .count(rx_cnt));

   // sticky error flags: set wins over a same-cycle clear
   logic st_brk, st_frm, st_ovr;
   logic ovr_evt;
   assign ovr_evt = rx_got && rx_full;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_brk <= 1'b0; st_frm <= 1'b0; st_ovr <= 1'b0;
      end else begin
         st_brk <= brk_evt || (st_brk && !(wr_sts && bus_wdata[S_BRK]));
         st_frm <= frm_evt || (st_frm && !(wr_sts && bus_wdata[S_FRM]));
         st_ovr <= ovr_evt || (st_ovr && !(wr_sts && bus_wdata[S_OVR]));
      end
   end

   logic [5:0]  cond;
   logic [31:0] sts, ctl;
   assign cond = {!tx_full, !rx_empty, st_brk, st_frm, 1'b0, st_ovr};
   always_comb begin
      sts = '0;
      sts[S_TXEMPTY] = tx_empty;
      sts[S_TXFULL]  = tx_full;
      sts[S_TXHALF]  = tx_cnt >= TCW'(HALF);
      sts[5:0]       = cond;
      ctl = '0;
      ctl[C_TXFLUSH] = fl_tx;
      ctl[C_RXFLUSH] = fl_rx;
      ctl[5:0]       = en;
   end

   always_comb begin
      case (idx)
         IDX_RXD:  bus_rdata = rx_empty ? 32'd0 : {{(32-BYTE_W){1'b0}}, rx_head};
         IDX_CTRL: bus_rdata = ctl;
         IDX_STS:  bus_rdata = sts;
         default:  bus_rdata = 32'd0;
      endcase
   end

   assign irq = |(cond & en);

   a_r9_tx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_tx && !wr_ctrl) |=> !fl_tx);
   a_r9_rx_flushed: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_rx && !rx_got) |=> rx_empty);
   a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovr && !wr_sts) |=> st_ovr);
   a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_got && rx_full) |=> (st_ovr && rx_full));
endmodule

// File: tb/test_serial_port_mm.sv
module test_serial_port_mm;
   localparam int DIV   = 16;
   localparam int TXD_N = 32;
   localparam int RXD_N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        txd, irq;
   logic        rxd = 1'b1;

   int total = 0, bad = 0;
   logic [7:0] mon_q[$];
   logic [7:0] exp_q[$];
   logic [31:0] rv;

   always #10 clk = ~clk;

   serial_port_mm #(.CLKS_PER_BIT(DIV), .TX_DEPTH(TXD_N), .RX_DEPTH(RXD_N)) i_serial_port_mm (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .txd(txd), .rxd(rxd), .irq(irq));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sts_exp(input int txcnt, input bit rxrdy, input logic [3:0] err);
      logic [31:0] s = '0;
      s[13] = (txcnt == 0);
      s[11] = (txcnt == TXD_N);
      s[10] = (txcnt >= TXD_N/2);
      s[5]  = (txcnt != TXD_N);
      s[4]  = rxrdy;
      s[3:0] = err;
      return s;
   endfunction

   task automatic bwr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic brd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #5 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input bit stop_ok);
      @(negedge clk);
      rxd = 1'b0; repeat (DIV) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i]; repeat (DIV) @(negedge clk);
      end
      rxd = stop_ok; repeat (DIV) @(negedge clk);
      if (!stop_ok) repeat (2*DIV) @(negedge clk);
      rxd = 1'b1; repeat (DIV) @(negedge clk);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   // serial monitor on txd (R2)
   initial begin
      logic [7:0] b;
      @(posedge rst_n);
      forever begin
         @(negedge txd);
         repeat (DIV/2) @(posedge clk); #1;
         chk(txd == 1'b0, "R2 start bit", 32'(txd), 0);
         for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(posedge clk); #1;
            b[i] = txd;
         end
         repeat (DIV) @(posedge clk); #1;
         chk(txd == 1'b1, "R2 stop bit", 32'(txd), 1);
         mon_q.push_back(b);
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      void'($urandom(32'h51A7));
      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(2);

      // R1 reset state
      brd(4'hC, rv); chk(rv == 32'h2020, "R1 status reset", rv, 32'h2020);
      brd(4'h8, rv); chk(rv == 0, "R1 control reset", rv, 0);
      chk(irq == 0, "R1 irq reset", 32'(irq), 0);

      // R2 random stream
      mon_q.delete(); exp_q.delete();
      for (int i = 0; i < 10; i++) begin
         b = 8'($urandom_range(0, 255));
         exp_q.push_back(b);
         bwr(4'h4, {24'hABCDEF, b});
      end
      wait_cycles(11 * 10 * DIV);
      chk(mon_q.size() == 10, "R2 frame count", mon_q.size(), 10);
      for (int i = 0; i < 10 && i < mon_q.size(); i++)
         chk(mon_q[i] == exp_q[i], "R2 byte order", mon_q[i], exp_q[i]);

      // R3/R4 burst of TXD_N+2 writes: one goes straight to the serializer, last dropped
      mon_q.delete(); exp_q.delete();
      for (int i = 0; i < TXD_N + 2; i++) begin
         b = 8'($urandom_range(0, 255));
         exp_q.push_back(b);
         bwr(4'h4, {24'h0, b});
      end
      brd(4'hC, rv);
      chk(rv == sts_exp(TXD_N, 0, 0), "R3 full flags", rv, sts_exp(TXD_N, 0, 0));
      wait_cycles((TXD_N + 3) * 10 * DIV);
      chk(mon_q.size() == TXD_N + 1, "R4 dropped write", mon_q.size(), TXD_N + 1);
      for (int i = 0; i < TXD_N + 1 && i < mon_q.size(); i++)
         chk(mon_q[i] == exp_q[i], "R4 stored bytes", mon_q[i], exp_q[i]);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 0), "R3 empty after drain", rv, sts_exp(0, 0, 0));

      // R3 half flag, R9 transmit flush
      mon_q.delete(); exp_q.delete();
      for (int i = 0; i < 20; i++) begin
         b = 8'(i * 7 + 3);
         exp_q.push_back(b);
         bwr(4'h4, {24'h0, b});
      end
      brd(4'hC, rv);
      chk(rv == sts_exp(19, 0, 0), "R3 half flag", rv, sts_exp(19, 0, 0));
      bwr(4'h8, 32'h8000);
      wait_cycles(3);
      brd(4'h8, rv); chk(rv == 0, "R9 tx flush self-clear", rv, 0);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 0), "R9 tx flushed", rv, sts_exp(0, 0, 0));
      wait_cycles(3 * 10 * DIV);
      chk(mon_q.size() == 1, "R9 only frame in flight sent", mon_q.size(), 1);
      if (mon_q.size() > 0) chk(mon_q[0] == exp_q[0], "R9 frame in flight", mon_q[0], exp_q[0]);

      // R5 receive random bytes
      exp_q.delete();
      for (int i = 0; i < 5; i++) begin
         b = 8'($urandom_range(0, 255));
         exp_q.push_back(b);
         send_frame(b, 1'b1);
      end
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 1, 0), "R5 rx ready", rv, sts_exp(0, 1, 0));
      for (int i = 0; i < 5; i++) begin
         brd(4'h0, rv);
         chk(rv == {24'h0, exp_q[i]}, "R5 rx data", rv, {24'h0, exp_q[i]});
      end
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 0), "R5 rx ready clears", rv, sts_exp(0, 0, 0));

      // R6 overrun
      exp_q.delete();
      for (int i = 0; i < RXD_N + 1; i++) begin
         b = 8'(8'h30 + i);
         exp_q.push_back(b);
         send_frame(b, 1'b1);
      end
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 1, 4'b0001), "R6 overrun flag", rv, sts_exp(0, 1, 4'b0001));
      for (int i = 0; i < RXD_N; i++) begin
         brd(4'h0, rv);
         chk(rv == {24'h0, exp_q[i]}, "R6 kept bytes", rv, {24'h0, exp_q[i]});
      end
      brd(4'hC, rv);
      chk(rv[4] == 0, "R6 dropped byte", rv, 0);

      // R7 break and framing
      send_frame(8'h00, 1'b0);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 4'b1001), "R7 break", rv, sts_exp(0, 0, 4'b1001));
      send_frame(8'hA5, 1'b0);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 4'b1101), "R7 framing", rv, sts_exp(0, 0, 4'b1101));

      // R10 irq on enabled framing error
      bwr(4'h8, 32'h0000_0004);
      #5 chk(irq == 1, "R10 framing irq", 32'(irq), 1);

      // R8 write-one-to-clear
      bwr(4'hC, 32'h0);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 4'b1101), "R8 write 0 keeps", rv, sts_exp(0, 0, 4'b1101));
      bwr(4'hC, 32'h4);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 4'b1001), "R8 clear framing", rv, sts_exp(0, 0, 4'b1001));
      #5 chk(irq == 0, "R10 irq drops", 32'(irq), 0);
      bwr(4'hC, 32'hF);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 0), "R8 clear all", rv, sts_exp(0, 0, 0));

      // R10 tx ready and rx ready enables
      bwr(4'h8, 32'h0000_0010);
      #5 chk(irq == 0, "R10 rx enable, rx empty", 32'(irq), 0);
      bwr(4'h8, 32'h0000_0020);
      #5 chk(irq == 1, "R10 tx ready irq", 32'(irq), 1);
      bwr(4'h8, 32'h0000_0010);
      send_frame(8'h5A, 1'b1);
      send_frame(8'hC3, 1'b1);
      #5 chk(irq == 1, "R10 rx ready irq", 32'(irq), 1);

      // R9 receive flush
      bwr(4'h8, 32'h0000_4010);
      wait_cycles(3);
      brd(4'h8, rv); chk(rv == 32'h10, "R9 rx flush self-clear", rv, 32'h10);
      brd(4'hC, rv);
      chk(rv == sts_exp(0, 0, 0), "R9 rx flushed", rv, sts_exp(0, 0, 0));
      #5 chk(irq == 0, "R10 irq after flush", 32'(irq), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule